// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a receive frame that upstream filtering has already accepted, one byte at a time, and places it in host memory through a ring of 16-byte descriptors. The ring starts at a base address, and the block keeps its own ring index. For each descriptor it reads three words from memory:

- the status word, which holds the ownership flag;
- the control word, which holds the buffer size and the end-of-ring flag;
- the buffer address.

Frame bytes then go into the buffer until either the frame ends or the buffer is full. The block then writes the status word back, handing the descriptor to software.

A frame longer than one buffer continues into the following descriptors. The first segment and the last segment of a frame are flagged in their status words. When a descriptor still belongs to software, the block reports that no buffer is available and discards the rest of the frame. A buffer address that breaks the alignment rule, or a ring base that is not 16-byte aligned, stops the engine until reset and raises a bus-error event. Memory is reached through a simple word-wide request/ready master port with byte strobes.

Top module: `rx_desc_ring_wr`

## Requirements
- R1: No descriptor access happens, and no byte is taken (`byte_ready_o` stays 0), unless both `rx_en_i` and `rx_dma_en_i` are 1 when a frame begins. After reset all outputs are 0.
- R2: Descriptor n of the ring sits at `ring_base_i + 16*n`. Its status, control and buffer-address words are read at offsets 0, 4 and 8.
- R3: If status bit 31 (owner) reads 0, `ev_no_buf_o` pulses and every remaining byte of the frame is consumed and discarded. That descriptor is not written, and the ring index does not move.
- R4: Each segment carries min(bytes left, buffer size) bytes. Byte k of the segment is written at buffer address + k, using one byte strobe on the word-aligned address.
- R5: The status write-back has the segment length in bits 10:0, multicast in bit 16, broadcast in bit 17 and the last flag in bit 28. The first flag is in bit 29, and bits 31 (owner) and 22:18 (error) are 0. The broadcast and multicast flags are sampled together with the first byte.
- R6: The first flag is set only in the first descriptor of a frame. The last flag is set only in the descriptor that holds the final byte, including when that byte exactly fills the buffer.
- R7: The buffer size is taken from control bits 10:0. After each write-back the index becomes 0 if control bit 31 (end of ring) is set, and otherwise increases by 1.
- R8: When the final segment's write-back completes, `ev_rx_ok_o` and `ev_rx_done_o` pulse together for one cycle.
- R9: A buffer address whose bits 1:0 are not 2'b10 pulses `ev_bus_err_o`. The engine then makes no memory request and takes no byte until reset.
- R10: A ring base whose bits 3:0 are not zero pulses `ev_bus_err_o` at frame start, before any memory access, and halts the engine the same way.
- R11: While `mem_ready_i` is 0, a pending request keeps its address, write enable, strobes and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| byte_valid_i | input | 1 | Frame byte present |
| byte_data_i | input | 8 | Frame byte |
| byte_last_i | input | 1 | Marks the final byte of the frame |
| frame_bcast_i | input | 1 | Broadcast flag, valid with the first byte |
| frame_mcast_i | input | 1 | Multicast flag, valid with the first byte |
| byte_ready_o | output | 1 | Byte taken on this cycle when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_be_o | output | 4 | Byte strobes for writes |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Completes the request this cycle |
| ev_rx_ok_o | output | 1 | Frame received pulse |
| ev_rx_done_o | output | 1 | Frame finished pulse |
| ev_no_buf_o | output | 1 | Descriptor not owned pulse |
| ev_bus_err_o | output | 1 | Alignment fault pulse |

## Verification
The bench uses the default parameters, AW of 32 and IDX_W of 4. It marks end-of-ring on the fourth descriptor, so index wrap is reached long before the 16-entry index would overflow. Buffer sizes alternate between 8 and 5 bytes, so short frames, frames that exactly fill a buffer, and frames spanning four segments across the wrap all occur within six frames. The memory model withholds ready one cycle in four, so every request meets a stall at some point.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W     = 11;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
  localparam int BCAST_BIT = 17;
  localparam int MCAST_BIT = 16;
  localparam int EOR_BIT   = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STAT, ST_RD_CTRL, ST_RD_BUF,
    ST_DATA, ST_WR_BYTE, ST_WR_BACK, ST_DROP, ST_HALT
  } rxr_state_e;

  function automatic logic [31:0] build_status(
    input logic [LEN_W-1:0] len,
    input logic bc, input logic mc,
    input logic first, input logic last);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[BCAST_BIT] = bc;
    w[MCAST_BIT] = mc;
    w[FIRST_BIT] = first;
    w[LAST_BIT]  = last;
    w[OWN_BIT]   = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          eor_ld_i,
  input  logic          eor_i,
  input  logic          adv_i,
  output logic [AW-1:0] desc_addr_o
);
  localparam int DESC_SHIFT = 4;

  logic [IDX_W-1:0] idx_q;
  logic             eor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      eor_q <= 1'b0;
    end else begin
      if (eor_ld_i) eor_q <= eor_i;
      if (adv_i) idx_q <= eor_q ? '0 : idx_q + 1'b1;
    end
  end

  assign desc_addr_o = base_i + AW'({idx_q, {DESC_SHIFT{1'b0}}});
endmodule

// File: rtl/rxr_seg_track.sv
module rxr_seg_track #(
  parameter int AW = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sz_ld_i,
  input  logic [rxr_pkg::LEN_W-1:0] sz_i,
  input  logic                    buf_ld_i,
  input  logic [AW-1:0]           buf_i,
  input  logic                    inc_i,
  output logic                    buf_bad_o,
  output logic [rxr_pkg::LEN_W-1:0] cnt_o,
  output logic                    last_slot_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [3:0]              wr_be_o
);
  localparam int LW = rxr_pkg::LEN_W;

  logic [LW-1:0] sz_q, cnt_q;
  logic [AW-1:0] buf_q;
  logic [AW-1:0] byte_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sz_q  <= '0;
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      if (sz_ld_i) sz_q <= sz_i;
      if (buf_ld_i) begin
        buf_q <= buf_i;
        cnt_q <= '0;
      end else if (inc_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // valid buffers are halfword aligned but never word aligned
  assign buf_bad_o   = (buf_i[1:0] != 2'b10);
  assign byte_addr   = buf_q + AW'(cnt_q);
  assign wr_addr_o   = {byte_addr[AW-1:2], 2'b00};
  assign wr_be_o     = 4'b0001 << byte_addr[1:0];
  assign cnt_o       = cnt_q;
  assign last_slot_o = ((cnt_q + 1'b1) == sz_q);
endmodule

// File: rtl/rx_desc_ring_wr.sv
module rx_desc_ring_wr #(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          rx_dma_en_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  input  logic          byte_last_i,
  input  logic          frame_bcast_i,
  input  logic          frame_mcast_i,
  output logic          byte_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [3:0]    mem_be_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          ev_rx_ok_o,
  output logic          ev_rx_done_o,
  output logic          ev_no_buf_o,
  output logic          ev_bus_err_o
);
  import rxr_pkg::*;

  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_BUF  = AW'(8);

  rxr_state_e state_q;
  logic       first_q, last_q, bc_q, mc_q;
  logic [7:0] byte_q;

  logic [AW-1:0]    desc_addr, wr_addr;
  logic [3:0]       wr_be;
  logic [LEN_W-1:0] seg_cnt;
  logic             last_slot, buf_bad;
  logic             hs, sz_ld, buf_ld, cnt_inc, adv;

  assign hs      = mem_req_o & mem_ready_i;
  assign sz_ld   = (state_q == ST_RD_CTRL) & hs;
  assign buf_ld  = (state_q == ST_RD_BUF) & hs & ~buf_bad;
  assign cnt_inc = (state_q == ST_WR_BYTE) & hs;
  assign adv     = (state_q == ST_WR_BACK) & hs;

  rxr_ring_idx #(.AW(AW), .IDX_W(IDX_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (ring_base_i),
    .eor_ld_i    (sz_ld),
    .eor_i       (mem_rdata_i[EOR_BIT]),
    .adv_i       (adv),
    .desc_addr_o (desc_addr)
  );

  rxr_seg_track #(.AW(AW)) u_seg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sz_ld_i     (sz_ld),
    .sz_i        (mem_rdata_i[LEN_W-1:0]),
    .buf_ld_i    (buf_ld),
    .buf_i       (mem_rdata_i[AW-1:0]),
    .inc_i       (cnt_inc),
    .buf_bad_o   (buf_bad),
    .cnt_o       (seg_cnt),
    .last_slot_o (last_slot),
    .wr_addr_o   (wr_addr),
    .wr_be_o     (wr_be)
  );

  always_comb begin
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_be_o     = 4'b0000;
    mem_addr_o   = desc_addr;
    mem_wdata_o  = '0;
    byte_ready_o = 1'b0;
    unique case (state_q)
      ST_RD_STAT: mem_req_o = 1'b1;
      ST_RD_CTRL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + OFS_CTRL;
      end
      ST_RD_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + OFS_BUF;
      end
      ST_DATA, ST_DROP: byte_ready_o = 1'b1;
      ST_WR_BYTE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = wr_be;
        mem_addr_o  = wr_addr;
        mem_wdata_o = {4{byte_q}};
      end
      ST_WR_BACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'b1111;
        mem_wdata_o = build_status(seg_cnt, bc_q, mc_q, first_q, last_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      first_q      <= 1'b0;
      last_q       <= 1'b0;
      bc_q         <= 1'b0;
      mc_q         <= 1'b0;
      byte_q       <= '0;
      ev_rx_ok_o   <= 1'b0;
      ev_rx_done_o <= 1'b0;
      ev_no_buf_o  <= 1'b0;
      ev_bus_err_o <= 1'b0;
    end else begin
      ev_rx_ok_o   <= 1'b0;
      ev_rx_done_o <= 1'b0;
      ev_no_buf_o  <= 1'b0;
      ev_bus_err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rx_en_i && rx_dma_en_i && byte_valid_i) begin
            if (ring_base_i[3:0] != 4'h0) begin
              ev_bus_err_o <= 1'b1;
              state_q      <= ST_HALT;
            end else begin
              bc_q    <= frame_bcast_i;
              mc_q    <= frame_mcast_i;
              first_q <= 1'b1;
              state_q <= ST_RD_STAT;
            end
          end
        end
        ST_RD_STAT: if (hs) begin
          if (!mem_rdata_i[OWN_BIT]) begin
            ev_no_buf_o <= 1'b1;
            state_q     <= ST_DROP;
          end else begin
            state_q <= ST_RD_CTRL;
          end
        end
        ST_RD_CTRL: if (hs) state_q <= ST_RD_BUF;
        ST_RD_BUF: if (hs) begin
          if (buf_bad) begin
            ev_bus_err_o <= 1'b1;
            state_q      <= ST_HALT;
          end else begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (byte_valid_i) begin
          byte_q  <= byte_data_i;
          last_q  <= byte_last_i;
          state_q <= ST_WR_BYTE;
        end
        ST_WR_BYTE: if (hs) state_q <= (last_q || last_slot) ? ST_WR_BACK : ST_DATA;
        ST_WR_BACK: if (hs) begin
          first_q <= 1'b0;
          if (last_q) begin
            ev_rx_ok_o   <= 1'b1;
            ev_rx_done_o <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            state_q <= ST_RD_STAT;
          end
        end
        ST_DROP: if (byte_valid_i && byte_last_i) state_q <= ST_IDLE;
        ST_HALT: ;
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_ring_wr_chk.sv
module rx_desc_ring_wr_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [3:0]    mem_be_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ready_i,
  input logic          ev_rx_ok_o,
  input logic          ev_rx_done_o,
  input logic          ev_bus_err_o
);
  logic halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else if (ev_bus_err_o) halted_q <= 1'b1;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_be_o) && $stable(mem_wdata_o));

  // R8
  ok_done_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_ok_o |-> ev_rx_done_o);

  // R8
  ok_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_ok_o |=> !ev_rx_ok_o);

  // R5
  owner_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o == 4'hf |-> !mem_wdata_o[31] && mem_wdata_o[22:18] == 5'd0);

  // R4
  byte_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o != 4'hf |-> $countones(mem_be_o) == 1);

  // R2
  desc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[1:0] == 2'b00 && mem_addr_o[3:2] != 2'b11);

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> !mem_req_o && !byte_ready_o);
endmodule

bind rx_desc_ring_wr rx_desc_ring_wr_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_ready_o (byte_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .ev_rx_ok_o   (ev_rx_ok_o),
  .ev_rx_done_o (ev_rx_done_o),
  .ev_bus_err_o (ev_bus_err_o)
);

// File: tb/rx_desc_ring_wr_bench.sv
`timescale 1ns/1ps
module rx_desc_ring_wr_bench;
  localparam int AW = 32;
  localparam int IDX_W = 4;
  localparam int NDESC = 4;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUF0 = 32'h402;
  localparam logic [31:0] BUF_STEP = 32'h40;
  localparam int NFR = 6;
  // {length[10:0], bcast, mcast}
  localparam logic [12:0] FRAMES [NFR] = '{
    {11'd3,  1'b1, 1'b0},
    {11'd8,  1'b0, 1'b0},
    {11'd13, 1'b0, 1'b1},
    {11'd20, 1'b0, 1'b0},
    {11'd1,  1'b1, 1'b0},
    {11'd5,  1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rx_en = 1'b0, rx_dma_en = 1'b0;
  logic [AW-1:0] ring_base = BASE;
  logic          byte_valid = 1'b0, byte_last = 1'b0;
  logic [7:0]    byte_data = 8'h00;
  logic          f_bc = 1'b0, f_mc = 1'b0;
  logic          byte_ready, mem_req, mem_we, mem_ready;
  logic [3:0]    mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          ev_ok, ev_done, ev_nobuf, ev_berr;

  rx_desc_ring_wr #(.AW(AW), .IDX_W(IDX_W)) u_rx_desc_ring_wr (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_dma_en_i(rx_dma_en),
    .ring_base_i(ring_base), .byte_valid_i(byte_valid), .byte_data_i(byte_data),
    .byte_last_i(byte_last), .frame_bcast_i(f_bc), .frame_mcast_i(f_mc),
    .byte_ready_o(byte_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_be_o(mem_be), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .ev_rx_ok_o(ev_ok), .ev_rx_done_o(ev_done), .ev_no_buf_o(ev_nobuf),
    .ev_bus_err_o(ev_berr)
  );

  logic [31:0] mem [512];
  logic [1:0]  rdy_cnt = 2'd0;
  logic        host_we = 1'b0;
  logic [31:0] host_addr = '0, host_data = '0;
  int n_ok = 0, n_done = 0, n_nobuf = 0, n_berr = 0, n_brdy = 0, n_mreq = 0, n_mwr = 0;
  int n_chk = 0, n_fail = 0;

  assign mem_ready = (rdy_cnt != 2'd3);
  assign mem_rdata = mem[mem_addr[10:2]];

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    if (host_we) mem[host_addr[10:2]] <= host_data;
    else if (mem_req && mem_we && mem_ready)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(posedge clk) begin
    if (ev_ok) n_ok <= n_ok + 1;
    if (ev_done) n_done <= n_done + 1;
    if (ev_nobuf) n_nobuf <= n_nobuf + 1;
    if (ev_berr) n_berr <= n_berr + 1;
    if (byte_ready) n_brdy <= n_brdy + 1;
    if (mem_req) n_mreq <= n_mreq + 1;
    if (mem_req && mem_we && mem_ready) n_mwr <= n_mwr + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [7:0] pay(input int k, input int j);
    return 8'(k * 37 + j * 3 + 1);
  endfunction

  function automatic int dsz(input int k);
    return (k % 2 == 0) ? 8 : 5;
  endfunction

  task automatic host_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm_ring(input int noown);
    for (int k = 0; k < NDESC; k++) begin
      host_write(BASE + 32'(16 * k), (k == noown) ? 32'h0 : 32'h8000_0000);
      host_write(BASE + 32'(16 * k) + 32'd4, 32'(dsz(k)) | ((k == NDESC - 1) ? 32'h8000_0000 : 32'h0));
      host_write(BASE + 32'(16 * k) + 32'd8, BUF0 + BUF_STEP * 32'(k));
    end
  endtask

  task automatic send_frame(input int k, input int len, input bit bc, input bit mc);
    f_bc = bc; f_mc = mc;
    for (int j = 0; j < len; j++) begin
      int t;
      t = 0;
      byte_valid = 1'b1; byte_data = pay(k, j); byte_last = (j == len - 1);
      while (!byte_ready && t < 2000) begin
        @(negedge clk); t++;
      end
      @(negedge clk);
    end
    byte_valid = 1'b0; byte_last = 1'b0;
  endtask

  task automatic wait_ok(input int ok0);
    for (int t = 0; t < 500 && n_ok == ok0; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    byte_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input int seg, input bit bc, input bit mc, input bit first, input bit last);
    return 32'(seg) | (32'(mc) << 16) | (32'(bc) << 17) | (32'(last) << 28) | (32'(first) << 29);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    int idx_m;
    int ok0, dn0, nb0, be0, br0, mr0, mw0;
    do_reset();
    // R1 reset values
    check(!byte_ready && !mem_req && !ev_ok && !ev_done && !ev_nobuf && !ev_berr,
          "R1 reset outputs", {26'd0, byte_ready, mem_req, ev_ok, ev_done, ev_nobuf, ev_berr}, 32'd0);
    arm_ring(-1);

    // R1 either enable low blocks everything
    br0 = n_brdy; mr0 = n_mreq;
    rx_en = 1'b0; rx_dma_en = 1'b1; byte_valid = 1'b1; byte_data = 8'hAA;
    repeat (30) @(negedge clk);
    check(n_brdy == br0 && n_mreq == mr0, "R1 rx_en low", 32'(n_mreq - mr0), 32'd0);
    rx_en = 1'b1; rx_dma_en = 1'b0;
    repeat (30) @(negedge clk);
    check(n_brdy == br0 && n_mreq == mr0, "R1 dma_en low", 32'(n_mreq - mr0), 32'd0);
    byte_valid = 1'b0; rx_dma_en = 1'b1;
    @(negedge clk);

    idx_m = 0;
    for (int k = 0; k < NFR; k++) begin
      int len, rem, off, seg;
      bit bc, mc, first;
      len = int'(FRAMES[k][12:2]); bc = FRAMES[k][1]; mc = FRAMES[k][0];
      arm_ring(-1);
      ok0 = n_ok; dn0 = n_done;
      send_frame(k, len, bc, mc);
      wait_ok(ok0);
      // R8
      check(n_ok == ok0 + 1 && n_done == dn0 + 1, "R8 ok/done once", 32'(n_ok - ok0), 32'd1);
      rem = len; off = 0; first = 1'b1;
      while (rem > 0) begin
        logic [31:0] w0, exp;
        bit good;
        seg = (rem < dsz(idx_m)) ? rem : dsz(idx_m);
        w0 = mem[(BASE[10:0] + 11'(16 * idx_m)) >> 2];
        exp = exp_stat(seg, bc, mc, first, rem == seg);
        // R2 R5 R6 R7: descriptor chosen by wrap model, status layout
        check(w0 == exp, "R5 R6 R7 R2 status word", w0, exp);
        good = 1'b1;
        for (int j = 0; j < seg; j++) begin
          logic [31:0] a;
          a = BUF0 + BUF_STEP * 32'(idx_m) + 32'(j);
          if (mem[a[10:2]][8*a[1:0] +: 8] != pay(k, off + j)) good = 1'b0;
        end
        // R4 R11 data placement under memory stalls
        check(good, "R4 R11 segment bytes", 32'(good), 32'd1);
        off += seg; rem -= seg; first = 1'b0;
        idx_m = (idx_m == NDESC - 1) ? 0 : idx_m + 1;
      end
    end

    // R3 descriptor held by software
    arm_ring(idx_m);
    ok0 = n_ok; nb0 = n_nobuf;
    send_frame(9, 4, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(n_nobuf == nb0 + 1, "R3 no-buffer event", 32'(n_nobuf - nb0), 32'd1);
    check(n_ok == ok0, "R3 no ok event", 32'(n_ok - ok0), 32'd0);
    check(mem[(BASE[10:0] + 11'(16 * idx_m)) >> 2] == 32'h0, "R3 descriptor untouched",
          mem[(BASE[10:0] + 11'(16 * idx_m)) >> 2], 32'h0);
    arm_ring(-1);
    ok0 = n_ok;
    send_frame(10, 2, 1'b0, 1'b0);
    wait_ok(ok0);
    check(mem[(BASE[10:0] + 11'(16 * idx_m)) >> 2] == exp_stat(2, 0, 0, 1, 1), "R3 index unchanged",
          mem[(BASE[10:0] + 11'(16 * idx_m)) >> 2], exp_stat(2, 0, 0, 1, 1));

    // R9 word-aligned buffer, then odd buffer
    for (int v = 0; v < 2; v++) begin
      do_reset();
      arm_ring(-1);
      host_write(BASE + 32'd8, (v == 0) ? 32'h404 : 32'h403);
      be0 = n_berr; br0 = n_brdy; mw0 = n_mwr;
      byte_valid = 1'b1; byte_data = 8'h55; byte_last = 1'b0;
      repeat (40) @(negedge clk);
      check(n_berr == be0 + 1, "R9 bus error event", 32'(n_berr - be0), 32'd1);
      check(n_brdy == br0 && n_mwr == mw0, "R9 halted", 32'(n_brdy - br0), 32'd0);
      byte_valid = 1'b0;
    end

    // R10 misaligned ring base
    do_reset();
    ring_base = BASE + 32'h8;
    be0 = n_berr; mr0 = n_mreq; br0 = n_brdy;
    byte_valid = 1'b1;
    repeat (30) @(negedge clk);
    check(n_berr == be0 + 1, "R10 bus error event", 32'(n_berr - be0), 32'd1);
    check(n_mreq == mr0 && n_brdy == br0, "R10 no access", 32'(n_mreq - mr0), 32'd0);
    byte_valid = 1'b0;
    ring_base = BASE;

    summary();
    $finish;
  end
endmodule